// File: doc/BRIEF.md
# Magnitude Moving-Average Detector

This block watches a stream of wide signed samples, such as the output of a digital filter, and reports how strong the stream has been over a recent window. A valid strobe qualifies each sample. For every qualified sample the block takes the absolute value and discards the low 28 bits, which leaves a 16-bit level. It then keeps the mean of the last 1024 levels. The result is large while the filter passes the incoming signal and small while the filter rejects it.

The mean comes from a running sum that is updated incrementally. Each new level is added to the sum, and the level written 1024 samples earlier is subtracted. A 1024-entry circular buffer holds these older levels. It is an inferred single-port RAM that reads the old entry before writing the new one. The average is the sum shifted right by 10 bits. It is announced by a one-cycle valid pulse and holds its value between pulses.

Window length, input width and scale shift are parameters. The defaults are a 44-bit input, a shift of 28 (so the level is 16 bits) and a window of 2^10 entries.

Top module: `mag_avg_top`

## Requirements
- R1: After reset, `outValid` is 0 and `outAvg` is 0 until the first result leaves the pipeline.
- R2: The magnitude of a sample is its two's-complement absolute value. The most negative input gives 2^(IN_W-1) without wrapping.
- R3: The level is the magnitude shifted right by SHIFT bits (default 28), which gives SCALE_W = IN_W - SHIFT bits (default 16).
- R4: On each valid sample the running sum gains the new level and loses the level stored WINDOW = 2^DEPTH_LOG2 valid samples earlier (default 1024). Until WINDOW samples have arrived since reset, the subtracted level is zero.
- R5: `outAvg` equals the running sum shifted right by DEPTH_LOG2 bits (floor division by the window length).
- R6: `outValid` is a one-cycle pulse two clock cycles after each cycle with `inValid` high. Back-to-back valid samples give back-to-back pulses, each with its own result.
- R7: Cycles with `inValid` low change neither the buffer pointer nor the running sum, so `outAvg` holds its last value.
- R8: The running sum is SCALE_W + DEPTH_LOG2 bits wide and never overflows. A full window of most-negative samples gives an average of 2^(SCALE_W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies `inData` on this cycle |
| inData | input | IN_W | Signed two's-complement sample |
| outValid | output | 1 | One-cycle pulse marking a fresh average |
| outAvg | output | SCALE_W | Window average of the levels |

## Verification
On every cycle the assertions check four things:
- the two-cycle pulse timing in both directions;
- that the write pointer steps by one per valid sample and stands still otherwise;
- that the window-filled flag never clears;
- that the running sum stays below its theoretical maximum and is frozen when no accumulate strobe is present.

The arithmetic itself can only be shown by the bench. It drives a reduced configuration (12-bit input, shift 4, 16-deep window) and sweeps every input code back to back. It also covers sparse valid patterns and a window full of the most negative value. Each average is compared with a fresh re-summation of the bench's own window model.

// File: rtl/mag_avg_pkg.sv
package mag_avg_pkg;
  // Strobes from control to datapath for one pipeline slot
  typedef struct packed {
    logic load;     // stage 1: capture level, read old entry, write new one
    logic accum;    // stage 2: update running sum
    logic oldZero;  // stage 2: treat the read-back entry as zero (window not yet full)
  } strobe_t;
endpackage

// File: rtl/mag_avg_buffer.sv
module mag_avg_buffer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: the old entry is returned while the new one is written
  always_ff @(posedge clk) begin
    if (we) begin
      rdData    <= mem[addr];
      mem[addr] <= wrData;
    end
  end
endmodule

// File: rtl/mag_avg_ctrl.sv
module mag_avg_ctrl
  import mag_avg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output strobe_t           strobes,
  output logic [ADDR_W-1:0] wrPtr,
  output logic              outValid
);
  logic full;
  logic stage1Valid;
  logic oldZeroQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      full        <= 1'b0;
      stage1Valid <= 1'b0;
      oldZeroQ    <= 1'b1;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
      if (inValid) begin
        oldZeroQ <= !full;
        wrPtr    <= wrPtr + 1'b1;
        if (wrPtr == '1) full <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load    = inValid;
    strobes.accum   = stage1Valid;
    strobes.oldZero = oldZeroQ;
  end

  // R6: every pulse comes from a valid sample two cycles earlier
  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));
  // R6: every valid sample yields a pulse two cycles later
  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);
  // R4: pointer advances by exactly one per valid sample
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> wrPtr == ADDR_W'($past(wrPtr) + 1'b1));
  // R7: idle cycles leave the pointer alone
  a_r7_ptr_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(wrPtr));
  // R4: once the window has filled, old entries stay real
  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    full |=> full);
endmodule

// File: rtl/mag_avg_datapath.sv
module mag_avg_datapath
  import mag_avg_pkg::*;
#(
  parameter int IN_W      = 44,
  parameter int SHIFT     = 28,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  logic [IN_W-1:0]          inData,
  input  logic [IN_W-SHIFT-1:0]    rdOld,
  output logic [IN_W-SHIFT-1:0]    level,
  output logic [IN_W-SHIFT-1:0]    avg
);
  localparam int SCALE_W = IN_W - SHIFT;
  localparam int SUM_W   = SCALE_W + DEPTH_LOG2;
  localparam logic [SUM_W-1:0] SUM_MAX =
    SUM_W'(((2 ** SCALE_W) - 1)) << DEPTH_LOG2;

  logic [IN_W-1:0]    magnitude;
  logic [SCALE_W-1:0] levelQ;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   subtrahend;

  // R2: two's-complement absolute value, IN_W bits holds 2^(IN_W-1)
  always_comb begin
    magnitude = inData[IN_W-1] ? (~inData + 1'b1) : inData;
    level     = SCALE_W'(magnitude >> SHIFT);   // R3
  end

  always_ff @(posedge clk) begin
    if (!rstN) levelQ <= '0;
    else if (strobes.load) levelQ <= level;
  end

  assign subtrahend = strobes.oldZero ? '0 : SUM_W'(rdOld);

  // R4: recursive window update
  always_ff @(posedge clk) begin
    if (!rstN) sum <= '0;
    else if (strobes.accum) sum <= sum + SUM_W'(levelQ) - subtrahend;
  end

  assign avg = SCALE_W'(sum >> DEPTH_LOG2);   // R5

  // R8: the sum never exceeds a full window of maximum levels
  a_r8_sum_bound: assert property (@(posedge clk) disable iff (!rstN)
    sum <= SUM_MAX);
  // R7: without an accumulate strobe the sum is frozen
  a_r7_sum_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accum |=> $stable(sum));
endmodule

// File: rtl/mag_avg_top.sv
module mag_avg_top
  import mag_avg_pkg::*;
#(
  parameter int IN_W       = 44,
  parameter int SHIFT      = 28,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [IN_W-1:0]       inData,
  output logic                  outValid,
  output logic [IN_W-SHIFT-1:0] outAvg
);
  localparam int SCALE_W = IN_W - SHIFT;

  strobe_t               strobes;
  logic [DEPTH_LOG2-1:0] wrPtr;
  logic [SCALE_W-1:0]    level;
  logic [SCALE_W-1:0]    rdOld;

  mag_avg_ctrl #(.ADDR_W(DEPTH_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .wrPtr(wrPtr), .outValid(outValid)
  );

  mag_avg_buffer #(.DATA_W(SCALE_W), .ADDR_W(DEPTH_LOG2)) u_buffer (
    .clk(clk), .we(strobes.load), .addr(wrPtr),
    .wrData(level), .rdData(rdOld)
  );

  mag_avg_datapath #(.IN_W(IN_W), .SHIFT(SHIFT), .DEPTH_LOG2(DEPTH_LOG2)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .rdOld(rdOld), .level(level), .avg(outAvg)
  );
endmodule

// File: tb/mag_avg_top_tb.sv
module mag_avg_top_tb;
  localparam int IN_W = 12, SHIFT = 4, DL2 = 4;
  localparam int SW = IN_W - SHIFT, WIN = 1 << DL2;

  logic clk = 0, rstN = 0, inValid = 0;
  logic [IN_W-1:0] inData = '0;
  logic outValid;
  logic [SW-1:0] outAvg;

  int errors = 0, checks = 0;
  int hist [WIN];
  int wp = 0;
  bit pV1 = 0, pV2 = 0;
  int pA1 = 0, pA2 = 0, heldAvg = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  mag_avg_top #(.IN_W(IN_W), .SHIFT(SHIFT), .DEPTH_LOG2(DL2)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outAvg(outAvg)
  );

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // Model: |x| >> SHIFT into a window, average by full re-summation
  function automatic int push(logic [IN_W-1:0] d);
    int sd, mag, s;
    sd = int'($signed(d));
    mag = (sd < 0) ? -sd : sd;
    hist[wp] = mag >> SHIFT;
    wp = (wp + 1) % WIN;
    s = 0;
    for (int i = 0; i < WIN; i++) s += hist[i];
    return s >> DL2;
  endfunction

  task automatic step(bit v, logic [IN_W-1:0] d);
    @(negedge clk);
    check({tag, " R6 valid"}, int'(outValid), int'(pV2));
    if (pV2) heldAvg = pA2;
    check({tag, pV2 ? " R4 R5 avg" : " R7 hold"}, int'(outAvg), heldAvg);
    pV2 = pV1; pA2 = pA1;
    pV1 = v;  pA1 = v ? push(d) : 0;
    inValid = v; inData = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WIN; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 outAvg", int'(outAvg), 0);
    // R2 R3 R4 R5 R6: every code, back to back
    tag = "R2 R3 sweep";
    for (int c = 0; c < (1 << IN_W); c++) step(1'b1, IN_W'(c));
    // R7: sparse valids with idle gaps
    tag = "R7 sparse";
    for (int k = 0; k < 200; k++) begin
      step((k % 3) == 0, IN_W'((k * 377 + 91) % (1 << IN_W)));
    end
    // R2 R3: constant window of a negative value gives its exact level
    tag = "R2 R3 const";
    for (int k = 0; k < WIN + 2; k++) step(1'b1, IN_W'(-1000));
    repeat (2) step(1'b0, '0);
    check("R2 R3 const level", int'(outAvg), 1000 >> SHIFT);
    // R8: full window of most-negative samples
    tag = "R8 max";
    for (int k = 0; k < WIN + 4; k++) step(1'b1, {1'b1, {(IN_W-1){1'b0}}});
    repeat (3) step(1'b0, '0);
    check("R8 max avg", int'(outAvg), 1 << (SW - 1));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule